// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 64-bit virtual address into a physical address by reading four levels of translation tables from memory. A requester presents the address together with the kind of access (write, user-mode, instruction fetch). The walker first checks that the address is sign-extended correctly. It then fetches one 64-bit table entry per level through a simple request/response port. At the end it reports either the 4 KB frame address with the page offset added, or a fault code and the level where the walk stopped.

Permission bits are combined over every level visited. A page is writable only if all four entries allow writes, and user-accessible only if all four allow user access. A page is no-execute if any entry carries the execute-disable bit and the enable input is set. The walker serves one translation at a time. The caching attributes are taken from the final entry.

Top module: `ptw_walker`

## Requirements
- R1: After reset `req_ready` is 1 and `done_valid` and `mem_req_valid` are 0. `req_ready` is 1 only while no walk is in progress. A request is taken on a rising edge where `req_valid` and `req_ready` are both 1, and `req_ready` stays 0 until the walk ends.
- R2: An address whose bits 63:48 are not all equal to bit 47 ends with `done_fault`=1, `done_cause`=1 (non-canonical) and `done_level`=0. `done_valid` rises in the cycle after acceptance, and no memory read is made.
- R3: The reads visit the level-4, level-3, level-2 and level-1 tables in that order. Each read address is the table base plus 8 times the index. The indices come from address bits 47:39, 38:30, 29:21 and 20:12. The first base is `root_base` with bits 11:0 taken as zero.
- R4: The next table base, and at level 1 the frame base, is entry bits 39:12 with zeros below bit 12. Entry bits 62:40 and 11:5 have no effect.
- R5: An entry with bit 0 clear ends the walk with cause 2 (not-present). `done_level` gives the level of that entry (4 down to 1), and no further read is made. This fault takes precedence over any permission outcome.
- R6: `done_writable` is the AND of bit 1 over all four entries. `done_user` is the AND of bit 2 over all four entries.
- R7: A completed walk gives a protection fault (cause 3, `done_level`=1) when any of these holds: a write is requested and the page is not writable; a user access is requested and the page is not user-accessible; a fetch is requested and the page is no-execute.
- R8: `done_nx` is the OR of bit 63 over all four entries, ANDed with `nx_enable` as sampled when the request was taken.
- R9: `done_wt` and `done_cd` equal bits 3 and 4 of the level-1 entry. The same bits in higher-level entries have no effect.
- R10: A successful walk gives `done_fault`=0, `done_cause`=0 and `done_level`=0. `done_paddr` is the frame base with the address bits 11:0 placed below it.
- R11: `done_valid` is a one-cycle pulse. It rises in the cycle after the last entry is taken. On any fault, `done_paddr` and all attribute outputs are 0.
- R12: `mem_req_valid` is a one-cycle pulse for each read. It rises in the cycle after acceptance or after the previous response, and it stays low while a response is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made from user mode |
| req_exec | input | 1 | Access is an instruction fetch |
| nx_enable | input | 1 | Execute-disable bits are honoured |
| root_base | input | PA_W | Physical base of the level-4 table |
| mem_req_valid | output | 1 | Entry read request pulse |
| mem_req_addr | output | PA_W | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | ENTRY_W | Entry read data |
| done_valid | output | 1 | Result pulse |
| done_fault | output | 1 | Walk ended in a fault |
| done_cause | output | 2 | 0 none, 1 non-canonical, 2 not-present, 3 protection |
| done_level | output | LVL_W | Level of the fault (4..1), 0 otherwise |
| done_paddr | output | PA_W | Translated physical address |
| done_writable | output | 1 | Combined write permission |
| done_user | output | 1 | Combined user permission |
| done_nx | output | 1 | Page is no-execute |
| done_wt | output | 1 | Write-through from the level-1 entry |
| done_cd | output | 1 | Cache-disable from the level-1 entry |

## Verification
Every result has a fixed latency that counts from a known event:

- Each entry read is due one cycle after acceptance or one cycle after the previous response.
- The result pulse is due one cycle after the response that carries the last entry.
- For a non-canonical address, the result pulse is due one cycle after acceptance.

The bench model of the memory stamps each acceptance and each response with a cycle counter. It checks every read address and every result against those stamps plus one, and it samples on the falling edge. Its memory answers after one to three cycles, so each stamp rule is checked under several different gaps.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   // Entry flag positions; the walker and its neighbours decode these.
   localparam int PTE_P  = 0;
   localparam int PTE_W  = 1;
   localparam int PTE_U  = 2;
   localparam int PTE_WT = 3;
   localparam int PTE_CD = 4;
   localparam int PTE_NX = 63;

   typedef enum logic [1:0] {
      FLT_NONE     = 2'd0,
      FLT_NONCANON = 2'd1,
      FLT_NOTPRES  = 2'd2,
      FLT_PROT     = 2'd3
   } flt_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } st_e;

   typedef struct packed {
      logic wr;
      logic usr;
      logic nx;
      logic wt;
      logic cd;
   } attr_t;

endpackage

// File: rtl/ptw_canon_check.sv
module ptw_canon_check #(
   parameter int VA_W    = 64,
   parameter int VA_USED = 48
) (
   input  logic [VA_W-1:0] vaddr,
   output logic            canon_ok
);

   generate
      if (VA_USED >= VA_W) begin : g_full
         assign canon_ok = 1'b1;
         logic unused_va;
         assign unused_va = ^vaddr;
      end else begin : g_ext
         localparam int HI_W = VA_W - VA_USED + 1;
         logic [HI_W-1:0] hi;
         assign hi       = vaddr[VA_W-1:VA_USED-1];
         assign canon_ok = (&hi) | ~(|hi);
         logic unused_lo;
         assign unused_lo = ^vaddr[VA_USED-2:0];
      end
   endgenerate

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter  int VA_USED     = 48,
   parameter  int PA_W        = 40,
   parameter  int LEVELS      = 4,
   parameter  int IDX_W       = 9,
   parameter  int PG_SHIFT    = 12,
   parameter  int ENTRY_BYTES = 8,
   localparam int LW          = $clog2(LEVELS),
   localparam int PFN_W       = PA_W - PG_SHIFT
) (
   input  logic [VA_USED-1:0] va,
   input  logic [LW-1:0]      lvl,
   input  logic [PFN_W-1:0]   base_pfn,
   output logic [PA_W-1:0]    addr
);

   localparam int ESH = $clog2(ENTRY_BYTES);

   logic [IDX_W-1:0]    idx [LEVELS];
   logic [PG_SHIFT-1:0] off;

   genvar g;
   generate
      for (g = 0; g < LEVELS; g++) begin : g_idx
         assign idx[g] = va[PG_SHIFT + g*IDX_W +: IDX_W];
      end
   endgenerate

   always_comb begin
      off  = PG_SHIFT'(idx[lvl]) << ESH;
      addr = {base_pfn, off};
   end

   logic unused_off;
   assign unused_off = ^va[PG_SHIFT-1:0];

endmodule

// File: rtl/ptw_attr_accum.sv
module ptw_attr_accum
   import ptw_pkg::*;
#(
   parameter int ENTRY_W = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               load,
   input  logic [ENTRY_W-1:0] entry,
   output attr_t              nxt
);

   logic all_wr_q;
   logic all_usr_q;
   logic any_nx_q;

   always_comb begin
      nxt.wr  = all_wr_q  & entry[PTE_W];
      nxt.usr = all_usr_q & entry[PTE_U];
      nxt.nx  = any_nx_q  | entry[PTE_NX];
      nxt.wt  = entry[PTE_WT];
      nxt.cd  = entry[PTE_CD];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         all_wr_q  <= 1'b1;
         all_usr_q <= 1'b1;
         any_nx_q  <= 1'b0;
      end else if (clear) begin
         all_wr_q  <= 1'b1;
         all_usr_q <= 1'b1;
         any_nx_q  <= 1'b0;
      end else if (load) begin
         all_wr_q  <= nxt.wr;
         all_usr_q <= nxt.usr;
         any_nx_q  <= nxt.nx;
      end
   end

   logic unused_bits;
   assign unused_bits = ^{entry[ENTRY_W-2:PTE_CD+1], entry[PTE_P]};

endmodule

// File: rtl/ptw_prot_check.sv
module ptw_prot_check
   import ptw_pkg::*;
(
   input  attr_t acc,
   input  logic  want_wr,
   input  logic  want_usr,
   input  logic  want_exec,
   input  logic  nx_en,
   output logic  fault,
   output logic  nx_eff
);

   always_comb begin
      nx_eff = nx_en & acc.nx;
      fault  = (want_wr   & ~acc.wr)
             | (want_usr  & ~acc.usr)
             | (want_exec & nx_eff);
   end

   logic unused_cache;
   assign unused_cache = acc.wt ^ acc.cd;

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter  int VA_W     = 64,
   parameter  int PA_W     = 40,
   parameter  int LEVELS   = 4,
   parameter  int IDX_W    = 9,
   parameter  int PG_SHIFT = 12,
   parameter  int ENTRY_W  = 64,
   localparam int LVL_W    = $clog2(LEVELS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VA_W-1:0]    req_vaddr,
   input  logic               req_write,
   input  logic               req_user,
   input  logic               req_exec,
   input  logic               nx_enable,
   input  logic [PA_W-1:0]    root_base,
   output logic               mem_req_valid,
   output logic [PA_W-1:0]    mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [ENTRY_W-1:0] mem_rsp_data,
   output logic               done_valid,
   output logic               done_fault,
   output logic [1:0]         done_cause,
   output logic [LVL_W-1:0]   done_level,
   output logic [PA_W-1:0]    done_paddr,
   output logic               done_writable,
   output logic               done_user,
   output logic               done_nx,
   output logic               done_wt,
   output logic               done_cd
);

   localparam int VA_USED     = PG_SHIFT + LEVELS * IDX_W;
   localparam int LW          = $clog2(LEVELS);
   localparam int PFN_W       = PA_W - PG_SHIFT;
   localparam int ENTRY_BYTES = ENTRY_W / 8;

   // elaboration-time parameter checks
   generate
      if (LEVELS < 2) begin : g_bad_levels
         $error("ptw_walker: LEVELS must be at least 2");
      end
      if (IDX_W + $clog2(ENTRY_BYTES) > PG_SHIFT) begin : g_bad_table
         $error("ptw_walker: a table does not fit in one page");
      end
      if (VA_USED > VA_W) begin : g_bad_va
         $error("ptw_walker: VA_W too small for the index fields");
      end
      if (ENTRY_W != 64) begin : g_bad_entry
         $error("ptw_walker: entries must be 64 bits wide");
      end
      if (PA_W <= PG_SHIFT || PA_W > ENTRY_W - 1) begin : g_bad_pa
         $error("ptw_walker: PA_W out of range");
      end
   endgenerate

   st_e                st_q;
   logic [VA_USED-1:0] va_q;
   logic [LW-1:0]      lvl_q;
   logic [PFN_W-1:0]   pfn_q;
   logic               wr_q;
   logic               usr_q;
   logic               ex_q;
   logic               nxen_q;

   logic  canon_ok;
   logic  accept;
   logic  rsp_take;
   logic  present;
   logic  acc_load;
   attr_t acc_nxt;
   logic  prot_fault;
   logic  nx_eff;

   assign req_ready     = (st_q == ST_IDLE);
   assign accept        = req_valid && req_ready;
   assign mem_req_valid = (st_q == ST_ISSUE);
   assign rsp_take      = (st_q == ST_WAIT) && mem_rsp_valid;
   assign present       = mem_rsp_data[PTE_P];
   assign acc_load      = rsp_take && present;

   ptw_canon_check #(
      .VA_W    (VA_W),
      .VA_USED (VA_USED)
   ) canon_i (
      .vaddr    (req_vaddr),
      .canon_ok (canon_ok)
   );

   ptw_addr_gen #(
      .VA_USED     (VA_USED),
      .PA_W        (PA_W),
      .LEVELS      (LEVELS),
      .IDX_W       (IDX_W),
      .PG_SHIFT    (PG_SHIFT),
      .ENTRY_BYTES (ENTRY_BYTES)
   ) addr_i (
      .va       (va_q),
      .lvl      (lvl_q),
      .base_pfn (pfn_q),
      .addr     (mem_req_addr)
   );

   ptw_attr_accum #(
      .ENTRY_W (ENTRY_W)
   ) accum_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .load  (acc_load),
      .entry (mem_rsp_data),
      .nxt   (acc_nxt)
   );

   ptw_prot_check prot_i (
      .acc       (acc_nxt),
      .want_wr   (wr_q),
      .want_usr  (usr_q),
      .want_exec (ex_q),
      .nx_en     (nxen_q),
      .fault     (prot_fault),
      .nx_eff    (nx_eff)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q          <= ST_IDLE;
         va_q          <= '0;
         lvl_q         <= '0;
         pfn_q         <= '0;
         wr_q          <= 1'b0;
         usr_q         <= 1'b0;
         ex_q          <= 1'b0;
         nxen_q        <= 1'b0;
         done_valid    <= 1'b0;
         done_fault    <= 1'b0;
         done_cause    <= FLT_NONE;
         done_level    <= '0;
         done_paddr    <= '0;
         done_writable <= 1'b0;
         done_user     <= 1'b0;
         done_nx       <= 1'b0;
         done_wt       <= 1'b0;
         done_cd       <= 1'b0;
      end else begin
         done_valid <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q   <= req_vaddr[VA_USED-1:0];
                  wr_q   <= req_write;
                  usr_q  <= req_user;
                  ex_q   <= req_exec;
                  nxen_q <= nx_enable;
                  if (!canon_ok) begin
                     done_valid    <= 1'b1;
                     done_fault    <= 1'b1;
                     done_cause    <= FLT_NONCANON;
                     done_level    <= '0;
                     done_paddr    <= '0;
                     done_writable <= 1'b0;
                     done_user     <= 1'b0;
                     done_nx       <= 1'b0;
                     done_wt       <= 1'b0;
                     done_cd       <= 1'b0;
                  end else begin
                     st_q  <= ST_ISSUE;
                     lvl_q <= LW'(LEVELS - 1);
                     pfn_q <= root_base[PA_W-1:PG_SHIFT];
                  end
               end
            end
            ST_ISSUE: begin
               st_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!present) begin
                     st_q          <= ST_IDLE;
                     done_valid    <= 1'b1;
                     done_fault    <= 1'b1;
                     done_cause    <= FLT_NOTPRES;
                     done_level    <= LVL_W'(lvl_q) + LVL_W'(1);
                     done_paddr    <= '0;
                     done_writable <= 1'b0;
                     done_user     <= 1'b0;
                     done_nx       <= 1'b0;
                     done_wt       <= 1'b0;
                     done_cd       <= 1'b0;
                  end else if (lvl_q == '0) begin
                     st_q       <= ST_IDLE;
                     done_valid <= 1'b1;
                     if (prot_fault) begin
                        done_fault    <= 1'b1;
                        done_cause    <= FLT_PROT;
                        done_level    <= LVL_W'(1);
                        done_paddr    <= '0;
                        done_writable <= 1'b0;
                        done_user     <= 1'b0;
                        done_nx       <= 1'b0;
                        done_wt       <= 1'b0;
                        done_cd       <= 1'b0;
                     end else begin
                        done_fault    <= 1'b0;
                        done_cause    <= FLT_NONE;
                        done_level    <= '0;
                        done_paddr    <= {mem_rsp_data[PA_W-1:PG_SHIFT],
                                          va_q[PG_SHIFT-1:0]};
                        done_writable <= acc_nxt.wr;
                        done_user     <= acc_nxt.usr;
                        done_nx       <= nx_eff;
                        done_wt       <= acc_nxt.wt;
                        done_cd       <= acc_nxt.cd;
                     end
                  end else begin
                     st_q  <= ST_ISSUE;
                     pfn_q <= mem_rsp_data[PA_W-1:PG_SHIFT];
                     lvl_q <= lvl_q - LW'(1);
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   logic unused_in;
   assign unused_in = ^{root_base[PG_SHIFT-1:0], mem_rsp_data[ENTRY_W-2:PA_W],
                        mem_rsp_data[PG_SHIFT-1:0]};

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
   parameter int VA_W     = 64,
   parameter int PA_W     = 40,
   parameter int PG_SHIFT = 12,
   parameter int VA_USED  = 48,
   parameter int LVL_W    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [VA_W-1:0]  req_vaddr,
   input logic             mem_req_valid,
   input logic             done_valid,
   input logic             done_fault,
   input logic [1:0]       done_cause,
   input logic [LVL_W-1:0] done_level,
   input logic [PA_W-1:0]  done_paddr,
   input logic             done_writable,
   input logic             done_user,
   input logic             done_nx,
   input logic             done_wt,
   input logic             done_cd
);

   logic [VA_W-VA_USED:0] hi;
   logic                  bad_va;
   logic [PG_SHIFT-1:0]   off_q;

   assign hi     = req_vaddr[VA_W-1:VA_USED-1];
   assign bad_va = !((&hi) || !(|hi));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      off_q <= '0;
      else if (req_valid && req_ready) off_q <= req_vaddr[PG_SHIFT-1:0];
   end

   logic unused_mid;
   assign unused_mid = ^req_vaddr[VA_USED-2:PG_SHIFT];

   assert_busy_no_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);

   assert_noncanon_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && bad_va) |=>
         (done_valid && done_fault && done_cause == 2'd1 && done_level == '0 && !mem_req_valid));

   assert_notpres_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && done_cause == 2'd2) |-> (done_level >= LVL_W'(1) && done_level <= LVL_W'(4)));

   assert_prot_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && done_cause == 2'd3) |-> (done_level == LVL_W'(1)));

   assert_ok_fields_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !done_fault) |-> (done_cause == 2'd0 && done_level == '0));

   assert_ok_offset_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !done_fault) |-> (done_paddr[PG_SHIFT-1:0] == off_q));

   assert_fault_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> (done_fault == (done_cause != 2'd0)));

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   assert_fault_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && done_fault) |->
         (done_paddr == '0 && !done_writable && !done_user && !done_nx && !done_wt && !done_cd));

   assert_read_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);

endmodule

bind ptw_walker ptw_walker_chk #(
   .VA_W     (VA_W),
   .PA_W     (PA_W),
   .PG_SHIFT (PG_SHIFT),
   .VA_USED  (PG_SHIFT + LEVELS * IDX_W),
   .LVL_W    (LVL_W)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_vaddr     (req_vaddr),
   .mem_req_valid (mem_req_valid),
   .done_valid    (done_valid),
   .done_fault    (done_fault),
   .done_cause    (done_cause),
   .done_level    (done_level),
   .done_paddr    (done_paddr),
   .done_writable (done_writable),
   .done_user     (done_user),
   .done_nx       (done_nx),
   .done_wt       (done_wt),
   .done_cd       (done_cd)
);

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic        req_exec = 1'b0;
   logic        nx_enable = 1'b0;
   logic [39:0] root_base = '0;
   logic        mem_req_valid;
   logic [39:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [63:0] mem_rsp_data;
   logic        done_valid;
   logic        done_fault;
   logic [1:0]  done_cause;
   logic [2:0]  done_level;
   logic [39:0] done_paddr;
   logic        done_writable;
   logic        done_user;
   logic        done_nx;
   logic        done_wt;
   logic        done_cd;

   always #5 clk = ~clk;

   ptw_walker dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_vaddr     (req_vaddr),
      .req_write     (req_write),
      .req_user      (req_user),
      .req_exec      (req_exec),
      .nx_enable     (nx_enable),
      .root_base     (root_base),
      .mem_req_valid (mem_req_valid),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .done_valid    (done_valid),
      .done_fault    (done_fault),
      .done_cause    (done_cause),
      .done_level    (done_level),
      .done_paddr    (done_paddr),
      .done_writable (done_writable),
      .done_user     (done_user),
      .done_nx       (done_nx),
      .done_wt       (done_wt),
      .done_cd       (done_cd)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit finished = 1'b0;

   // table bases: tbl[L] is the page number of the level-L table, tbl[0] the frame
   logic [27:0] tbl [0:4];
   // flags per level: [0] present [1] write [2] user [3] wt [4] cd [5] nx (bit 63)
   logic [5:0]  fl  [1:4];
   logic [63:0] cur_va = '0;
   int          g_lat = 1;
   int          rd_cnt = 0;
   int          req_cyc = 0;
   int          rsp_cyc = 0;
   logic [31:0] seed = 32'h1234_5678;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] rnd32();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed;
   endfunction

   function automatic logic [63:0] canon_va();
      logic [47:0] r;
      r = {rnd32(), rnd32()};
      r[47:32] = rnd32()[31:16];
      return {{16{r[47]}}, r};
   endfunction

   task automatic new_bases();
      for (int l = 0; l <= 4; l++) tbl[l] = rnd32()[27:0] ^ 28'(l * 32'h0113);
   endtask

   // memory model: checks each read address and its timing, answers after g_lat cycles
   initial begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      forever begin
         @(negedge clk);
         while (mem_req_valid) begin
            automatic int lv = 4 - rd_cnt;
            automatic logic [39:0] exp_a;
            if (lv < 1) begin
               chk(1'b0, "R5 read after walk end", 64'(rd_cnt), 64'd4);
               lv = 1;
            end
            exp_a = {tbl[lv], cur_va[12 + 9*(lv-1) +: 9], 3'b000};
            chk(mem_req_addr == exp_a, "R3 read address", 64'(mem_req_addr), 64'(exp_a));
            if (rd_cnt == 0)
               chk(cyc == req_cyc + 1, "R12 first read timing", 64'(cyc), 64'(req_cyc + 1));
            else
               chk(cyc == rsp_cyc + 1, "R12 next read timing", 64'(cyc), 64'(rsp_cyc + 1));
            rd_cnt++;
            for (int i = 0; i < g_lat; i++) begin
               @(negedge clk);
               chk(!mem_req_valid, "R12 read held while waiting", 64'(mem_req_valid), 64'd0);
            end
            mem_rsp_data  = {fl[lv][5], 23'h5A5A5A, tbl[lv-1], 7'h55, fl[lv][4:0]};
            mem_rsp_valid = 1'b1;
            rsp_cyc       = cyc;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
         end
      end
   end

   task automatic walk(input logic [63:0] va, input bit wr, input bit us, input bit ex,
                       input bit nxen, input int lat);
      bit          canon;
      bit          stop;
      int          exp_reads;
      logic [1:0]  exp_cause;
      logic [2:0]  exp_lvl;
      bit          w_all, u_all, nx_any, nxe, prot;
      logic [39:0] exp_pa;
      bit          e_w, e_u, e_nx, e_wt, e_cd;
      int          n;
      int          due;

      canon     = (va[63:47] == '1) || (va[63:47] == '0);
      exp_reads = 0;
      exp_cause = 2'd0;
      exp_lvl   = 3'd0;
      exp_pa    = '0;
      {e_w, e_u, e_nx, e_wt, e_cd} = '0;
      w_all = 1'b1; u_all = 1'b1; nx_any = 1'b0; stop = 1'b0;
      if (!canon) begin
         exp_cause = 2'd1;
         stop = 1'b1;
      end else begin
         for (int l = 4; l >= 1; l--) begin
            if (!stop) begin
               exp_reads++;
               if (!fl[l][0]) begin
                  exp_cause = 2'd2;
                  exp_lvl   = 3'(l);
                  stop      = 1'b1;
               end else begin
                  w_all  &= fl[l][1];
                  u_all  &= fl[l][2];
                  nx_any |= fl[l][5];
               end
            end
         end
         if (!stop) begin
            nxe  = nxen & nx_any;
            prot = (wr & !w_all) | (us & !u_all) | (ex & nxe);
            if (prot) begin
               exp_cause = 2'd3;
               exp_lvl   = 3'd1;
            end else begin
               exp_pa = {tbl[0], va[11:0]};
               {e_w, e_u, e_nx, e_wt, e_cd} = {w_all, u_all, nxe, fl[1][3], fl[1][4]};
            end
         end
      end

      @(negedge clk);
      n = 0;
      while (!req_ready && n < 100) begin
         @(negedge clk);
         n++;
      end
      cur_va    = va;
      g_lat     = lat;
      rd_cnt    = 0;
      req_vaddr = va;
      req_write = wr;
      req_user  = us;
      req_exec  = ex;
      nx_enable = nxen;
      root_base = {tbl[4], 12'hABC};
      req_valid = 1'b1;
      req_cyc   = cyc;
      @(negedge clk);
      req_valid = 1'b0;
      nx_enable = ~nxen;   // later changes must not matter (R8)
      if (canon) chk(!req_ready, "R1 not ready while busy", 64'(req_ready), 64'd0);
      n = 0;
      while (!done_valid && n < 200) begin
         @(negedge clk);
         n++;
      end
      if (!done_valid) begin
         chk(1'b0, "R11 result never arrived", 64'd0, 64'd1);
         return;
      end
      due = (exp_reads == 0) ? req_cyc + 1 : rsp_cyc + 1;
      chk(cyc == due, "R11 result timing", 64'(cyc), 64'(due));
      chk(done_fault == (exp_cause != 2'd0), "R10 fault flag", 64'(done_fault), 64'(exp_cause != 2'd0));
      chk(done_cause == exp_cause,
          exp_cause == 2'd1 ? "R2 cause" : exp_cause == 2'd2 ? "R5 cause" : "R7 cause",
          64'(done_cause), 64'(exp_cause));
      chk(done_level == exp_lvl, exp_cause == 2'd2 ? "R5 level" : "R7 level",
          64'(done_level), 64'(exp_lvl));
      chk(done_paddr == exp_pa, "R10 physical address", 64'(done_paddr), 64'(exp_pa));
      chk({done_writable, done_user} == {e_w, e_u}, "R6 combined permissions",
          64'({done_writable, done_user}), 64'({e_w, e_u}));
      chk(done_nx == e_nx, "R8 no-execute", 64'(done_nx), 64'(e_nx));
      chk({done_wt, done_cd} == {e_wt, e_cd}, "R9 cache attributes",
          64'({done_wt, done_cd}), 64'({e_wt, e_cd}));
      @(negedge clk);
      chk(!done_valid, "R11 one-cycle pulse", 64'(done_valid), 64'd0);
      chk(rd_cnt == exp_reads, exp_reads == 0 ? "R2 no read" : "R5 read count",
          64'(rd_cnt), 64'(exp_reads));
   endtask

   initial begin
      for (int l = 1; l <= 4; l++) fl[l] = 6'b000111;
      new_bases();
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
      chk(done_valid == 1'b0, "R1 reset result", 64'(done_valid), 64'd0);
      chk(mem_req_valid == 1'b0, "R1 reset read", 64'(mem_req_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);

      // R2: each upper bit flipped in a low canonical address, then high canonical addresses
      for (int b = 47; b < 64; b++) begin
         new_bases();
         walk(64'h0000_1234_5678_9ABC ^ (64'd1 << b), 1'b0, 1'b0, 1'b0, 1'b0, 1);
      end
      walk(64'hFFFF_8000_0000_0123, 1'b0, 1'b0, 1'b0, 1'b0, 2);
      walk(64'h0000_7FFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1);

      // R6, R7: every write/user permission pattern over four levels, every access kind
      for (int m = 0; m < 256; m++) begin
         for (int rq = 0; rq < 4; rq++) begin
            for (int l = 1; l <= 4; l++)
               fl[l] = {3'b000, m[2*(l-1)+1], m[2*(l-1)], 1'b1};
            new_bases();
            walk(canon_va(), rq[0], rq[1], 1'b0, 1'b0, 1 + (m + rq) % 3);
         end
      end

      // R8: execute-disable bits at each level with enable and fetch combinations
      for (int m = 0; m < 16; m++) begin
         for (int e = 0; e < 4; e++) begin
            for (int l = 1; l <= 4; l++) fl[l] = {m[l-1], 4'b0011, 1'b1};
            new_bases();
            walk(canon_va(), 1'b0, 1'b0, e[1], e[0], 1 + e % 2);
         end
      end

      // R9: cache bits at the leaf and at level 2
      for (int m = 0; m < 16; m++) begin
         for (int l = 1; l <= 4; l++) fl[l] = 6'b000111;
         fl[1][3] = m[0]; fl[1][4] = m[1];
         fl[2][3] = m[2]; fl[2][4] = m[3];
         new_bases();
         walk(canon_va(), 1'b0, 1'b0, 1'b0, 1'b0, 1);
      end

      // R5: not-present at each level, with a write that would also be refused
      for (int l = 1; l <= 4; l++) begin
         for (int k = 1; k <= 4; k++) fl[k] = 6'b000111;
         fl[4][1] = 1'b0;
         fl[l][0] = 1'b0;
         new_bases();
         walk(canon_va(), 1'b1, 1'b0, 1'b0, 1'b0, 3);
      end

      // R4: extreme frame and table bases
      for (int k = 1; k <= 4; k++) fl[k] = 6'b000111;
      for (int l = 0; l <= 4; l++) tbl[l] = (l % 2 == 0) ? 28'hFFF_FFFF : 28'h000_0001;
      walk(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, 2);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL R11 watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule